// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave

This block is a synthesizable model of a small nonvolatile byte memory that a host reaches over a four-wire serial port in clock mode 0: an active-low select, a serial clock, a data line into the block and a data line out of it. Two further pins give the board control: an active-low protect pin that freezes every stored value, and an active-low pause pin that suspends a transfer in mid-flight and lets it resume later. The port inputs are brought into the block's own clock domain through synchronizer chains, and serial clock edges are found by comparing successive synchronized samples. The serial clock must therefore be much slower than the system clock.

The array holds 256 bytes and is addressed by one address byte. A write instruction collects one to four bytes into a small page buffer. The bytes are committed when select returns high, and this starts a self-timed programming cycle. That cycle is modelled by a countdown of a parameter number of system clocks. While the cycle runs, the host can poll a status byte that reports busy, the write-enable latch and a two-bit protection level. The protection level fences off none, the top quarter, the top half or all of the array.

Top module: `spi_nvmem_slave`

## Requirements
- R1: After reset, the status byte reads 0x00 (busy, latch and protection level all clear), every array byte reads 0xFF, and `miso_oe` is low.
- R2: Opcode 0x03 followed by an address byte returns the byte at that address MSB first. The block samples `mosi` on rising `sck` and changes `miso` on falling `sck`.
- R3: A read continues while select stays low, advancing the address by one per byte and wrapping from 0xFF to 0x00.
- R4: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it.
- R5: Opcode 0x02, an address and 1 to 4 data bytes store the data once select rises. Each byte goes to the next address within the aligned group of four, wrapping from the group's last address to its first.
- R6: A write or status write issued while the latch is clear changes nothing and starts no programming cycle.
- R7: A committed write sets status bit 0 for BUSY_CYCLES clocks. During that time only opcode 0x05 (read status) is honoured. When the cycle ends, busy and the latch both clear.
- R8: Opcode 0x01 followed by a data byte loads status bits 3:2 from data bits 3:2. Protection levels 0, 1, 2 and 3 guard no address, 0xC0-0xFF, 0x80-0xFF and all addresses respectively.
- R9: A write aimed at a guarded address changes nothing, starts no cycle and leaves the latch set.
- R10: While `wp_n` is low, neither array writes nor status writes take effect, whatever the latch holds.
- R11: While `hold_n` is low, `sck` edges are ignored and `miso_oe` is low. After release, the transfer continues from the same bit.
- R12: A write whose select rises when a byte is only partly shifted in is discarded entirely.
- R13: Every select fall restarts instruction decode. An unknown opcode is ignored, and `miso_oe` stays low for the rest of that selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | High while `miso` should be driven onto the bus |
| wp_n | input | 1 | Active-low write protect |
| hold_n | input | 1 | Active-low transfer pause |

## Verification
On every cycle, the assertions check the following. The output enable stays low while the pause pin is held or select is high. A programming cycle never starts without the write-enable latch, and never starts while the protect pin is low. A busy period never lasts longer than BUSY_CYCLES, and the latch is clear when busy falls. Only the bench's scenarios can show data behaviour, because that depends on what was stored earlier. These behaviours include byte ordering on the wire, address wrap in reads, group wrap in writes, each protection level's address range, the discard of a misaligned write, and the resumption of a read after a pause at the exact bit where it stopped.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRIT = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_RADDR,
        ST_RDATA,
        ST_RSTAT,
        ST_WADDR,
        ST_WDATA,
        ST_SRDATA,
        ST_SKIP
    } nvm_state_e;

    // Level 0: nothing guarded, 1: top quarter, 2: top half, 3: everything.
    function automatic logic guarded(input logic [1:0] level, input logic [1:0] top2);
        case (level)
            2'd1:    guarded = (top2 == 2'b11);
            2'd2:    guarded = top2[1];
            2'd3:    guarded = 1'b1;
            default: guarded = 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] status_byte(input logic [1:0] level,
                                               input logic latch, input logic busy);
        status_byte = {4'b0000, level, latch, busy};
    endfunction

endpackage

// File: rtl/nvm_frontend.sv
module nvm_frontend #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic sck,
    input  logic mosi,
    input  logic hold_n,
    input  logic wp_n,
    output logic cs_active,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic hold_act,
    output logic wp_act
);
    localparam int          W       = 5;
    localparam logic [W-1:0] RST_VAL = 5'b11001; // {wp_n, hold_n, mosi, sck, csn}

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] raw;
    logic         csn_prev_q, sck_prev_q;
    logic         csn_s, sck_s;

    assign raw = {wp_n, hold_n, mosi, sck, csn};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage_q[g] <= RST_VAL;
                else if (g == 0) stage_q[g] <= raw;
                else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_prev_q <= 1'b1;
            sck_prev_q <= 1'b0;
        end else begin
            csn_prev_q <= csn_s;
            sck_prev_q <= sck_s;
        end
    end

    assign csn_s     = stage_q[STAGES-1][0];
    assign sck_s     = stage_q[STAGES-1][1];
    assign mosi_s    = stage_q[STAGES-1][2];
    assign hold_act  = !stage_q[STAGES-1][3];
    assign wp_act    = !stage_q[STAGES-1][4];
    assign cs_active = !csn_s;
    assign cs_fall   = csn_prev_q && !csn_s;
    assign cs_rise   = !csn_prev_q && csn_s;
    assign sck_rise  = cs_active && !hold_act &&  sck_s && !sck_prev_q;
    assign sck_fall  = cs_active && !hold_act && !sck_s &&  sck_prev_q;

endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int         ADDR_W     = 8,
    parameter int         PAGE_BYTES = 4,
    parameter logic [7:0] ERASED     = 8'hFF
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [7:0]                           rd_data,
    input  logic [PAGE_BYTES-1:0]                wr_en,
    input  logic [PAGE_BYTES-1:0][ADDR_W-1:0]    wr_addr,
    input  logic [PAGE_BYTES-1:0][7:0]           wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= ERASED;
        end else begin
            for (int l = 0; l < PAGE_BYTES; l++) begin
                if (wr_en[l]) cell_q[wr_addr[l]] <= wr_data[l];
            end
        end
    end

    assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 4,
    parameter int BUSY_CYCLES = 2000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cs_active,
    input  logic                              cs_fall,
    input  logic                              cs_rise,
    input  logic                              sck_rise,
    input  logic                              sck_fall,
    input  logic                              mosi_s,
    input  logic                              hold_act,
    input  logic                              wp_act,
    input  logic [7:0]                        rd_data,
    output logic [ADDR_W-1:0]                 rd_addr,
    output logic [PAGE_BYTES-1:0]             wr_en,
    output logic [PAGE_BYTES-1:0][ADDR_W-1:0] wr_addr,
    output logic [PAGE_BYTES-1:0][7:0]        wr_data,
    output logic                              miso,
    output logic                              miso_oe,
    output logic                              busy,
    output logic                              wel
);
    localparam int PIDX_W = $clog2(PAGE_BYTES);
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        nvm_state_e                    st;
        logic [2:0]                    bitc;
        logic [7:0]                    shin;
        logic [7:0]                    shout;
        logic [ADDR_W-1:0]             addr;
        logic                          miso;
        logic                          wel;
        logic [1:0]                    level;
        logic                          busy;
        logic [CNT_W-1:0]              cnt;
        logic [PAGE_BYTES-1:0][7:0]    page;
        logic [PAGE_BYTES-1:0]         valid;
        logic [1:0]                    sr_new;
        logic                          sr_pend;
    } ctrl_t;

    ctrl_t q, n;

    logic [7:0]        shin_next;
    logic              byte_done;
    logic              aligned;
    logic              may_write;
    logic [PIDX_W-1:0] idx;

    assign shin_next = {q.shin[6:0], mosi_s};
    assign byte_done = sck_rise && (q.bitc == 3'd7);
    assign aligned   = (q.bitc == 3'd0);
    assign may_write = q.wel && !wp_act && !q.busy && aligned;
    assign idx       = q.addr[PIDX_W-1:0];

    always_comb begin
        rd_addr = (q.st == ST_RADDR) ? shin_next[ADDR_W-1:0] : q.addr + 1'b1;
        for (int l = 0; l < PAGE_BYTES; l++) begin
            wr_addr[l] = {q.addr[ADDR_W-1:PIDX_W], PIDX_W'(l)};
            wr_data[l] = q.page[l];
        end
    end

    always_comb begin
        n     = q;
        wr_en = '0;

        // self-timed programming cycle
        if (q.busy) begin
            if (q.cnt == '0) begin
                n.busy = 1'b0;
                n.wel  = 1'b0;
            end else begin
                n.cnt = q.cnt - 1'b1;
            end
        end

        if (sck_rise) begin
            n.shin = shin_next;
            n.bitc = q.bitc + 1'b1;
        end

        if (sck_fall && (q.st == ST_RDATA || q.st == ST_RSTAT)) begin
            n.miso  = q.shout[7];
            n.shout = {q.shout[6:0], 1'b0};
        end

        if (byte_done) begin
            case (q.st)
                ST_CMD: begin
                    n.st = ST_SKIP;
                    if (shin_next == OP_RDSR) begin
                        n.st    = ST_RSTAT;
                        n.shout = status_byte(q.level, q.wel, q.busy);
                    end else if (!q.busy) begin
                        case (shin_next)
                            OP_WREN: n.wel = 1'b1;
                            OP_WRDI: n.wel = 1'b0;
                            OP_WRSR: n.st  = ST_SRDATA;
                            OP_READ: n.st  = ST_RADDR;
                            OP_WRIT: n.st  = ST_WADDR;
                            default: n.st  = ST_SKIP;
                        endcase
                    end
                end
                ST_RADDR: begin
                    n.addr  = shin_next[ADDR_W-1:0];
                    n.shout = rd_data;
                    n.st    = ST_RDATA;
                end
                ST_RDATA: begin
                    n.addr  = q.addr + 1'b1;
                    n.shout = rd_data;
                end
                ST_RSTAT: n.shout = status_byte(q.level, q.wel, q.busy);
                ST_WADDR: begin
                    n.addr = shin_next[ADDR_W-1:0];
                    n.st   = ST_WDATA;
                end
                ST_WDATA: begin
                    n.page[idx]  = shin_next;
                    n.valid[idx] = 1'b1;
                    n.addr       = {q.addr[ADDR_W-1:PIDX_W], PIDX_W'(idx + 1'b1)};
                end
                ST_SRDATA: begin
                    n.sr_new  = shin_next[3:2];
                    n.sr_pend = 1'b1;
                    n.st      = ST_SKIP;
                end
                default: ;
            endcase
        end

        if (cs_fall) begin
            n.st      = ST_CMD;
            n.bitc    = '0;
            n.miso    = 1'b0;
            n.valid   = '0;
            n.sr_pend = 1'b0;
        end

        if (cs_rise) begin
            if (q.st == ST_WDATA && (|q.valid) && may_write &&
                !guarded(q.level, q.addr[ADDR_W-1 -: 2])) begin
                wr_en  = q.valid;
                n.busy = 1'b1;
                n.cnt  = CNT_W'(BUSY_CYCLES - 1);
            end else if (q.sr_pend && may_write) begin
                n.level = q.sr_new;
                n.busy  = 1'b1;
                n.cnt   = CNT_W'(BUSY_CYCLES - 1);
            end
            n.st      = ST_IDLE;
            n.valid   = '0;
            n.sr_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign miso    = q.miso;
    assign miso_oe = cs_active && !hold_act && (q.st == ST_RDATA || q.st == ST_RSTAT);
    assign busy    = q.busy;
    assign wel     = q.wel;

endmodule

// File: rtl/spi_nvmem_slave.sv
module spi_nvmem_slave #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 4,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe,
    input  logic wp_n,
    input  logic hold_n
);
    logic cs_active, cs_fall, cs_rise, sck_rise, sck_fall, mosi_s, hold_act, wp_act;
    logic busy_w, wel_w;
    logic [7:0]                        rd_data;
    logic [ADDR_W-1:0]                 rd_addr;
    logic [PAGE_BYTES-1:0]             wr_en;
    logic [PAGE_BYTES-1:0][ADDR_W-1:0] wr_addr;
    logic [PAGE_BYTES-1:0][7:0]        wr_data;

    nvm_frontend #(.STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .wp_n(wp_n), .cs_active(cs_active), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .mosi_s(mosi_s), .hold_act(hold_act), .wp_act(wp_act)
    );

    nvm_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .mosi_s(mosi_s), .hold_act(hold_act), .wp_act(wp_act), .rd_data(rd_data),
        .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .miso(miso), .miso_oe(miso_oe), .busy(busy_w), .wel(wel_w)
    );

    nvm_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

endmodule

// File: rtl/nvm_chk.sv
module nvm_chk #(
    parameter int BUSY_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic wel,
    input logic hold_act,
    input logic wp_act,
    input logic cs_active,
    input logic miso_oe
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    // R11
    hold_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |-> !miso_oe);

    // R13
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |-> !miso_oe);

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= BUSY_CYCLES);

    // R7
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R10
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_act |=> !$rose(busy));

    // R6
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

endmodule

bind spi_nvmem_slave nvm_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .wel(wel_w), .hold_act(hold_act),
    .wp_act(wp_act), .cs_active(cs_active), .miso_oe(miso_oe)
);

// File: tb/tb_spi_nvmem_slave.sv
module tb_spi_nvmem_slave;
    localparam int BUSY = 600;
    localparam int HALF = 6;

    logic clk = 0, rst_n = 0;
    logic csn = 1, sck = 0, mosi = 0, wp_n = 1, hold_n = 1;
    logic miso, miso_oe;
    int   errors = 0, checks = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    spi_nvmem_slave #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .wp_n(wp_n), .hold_n(hold_n)
    );

    task automatic cw(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, inout logic [7:0] rx);
        for (int i = 0; i < n; i++) begin
            mosi = tx[7-i];
            cw(HALF);
            rx = {rx[6:0], miso};
            sck = 1;
            cw(HALF);
            sck = 0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        logic [7:0] r = 8'h00;
        xbits(tx, 8, r);
        rx = r;
    endtask

    task automatic cs_lo();
        csn = 0;
        cw(HALF);
    endtask

    task automatic cs_hi();
        cw(HALF);
        csn = 1;
        cw(2*HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_lo(); xbyte(op, d); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_lo(); xbyte(8'h05, d); xbyte(8'h00, s); cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_lo(); xbyte(8'h01, d); xbyte(v, d); cs_hi();
    endtask

    task automatic rd1(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] d;
        cs_lo(); xbyte(8'h03, d); xbyte(a, d); xbyte(8'h00, v); cs_hi();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] data, input int n);
        logic [7:0] d;
        cs_lo(); xbyte(8'h02, d); xbyte(a, d);
        for (int i = 0; i < n; i++) xbyte(data[31-8*i -: 8], d);
        cs_hi();
    endtask

    task automatic wait_ready();
        logic [7:0] s = 8'h01;
        int polls = 0;
        while (s[0] && polls < 40) begin
            rdsr(s);
            polls++;
        end
        checks++;
        if (s[0]) begin
            errors++;
            $display("FAIL R7: busy never cleared actual=%h expected=00", s);
        end
    endtask

    task automatic t_reset();
        logic [7:0] s, v;
        checks++;
        if (miso_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1: miso_oe actual=%b expected=0", miso_oe);
        end
        rdsr(s);   check8("R1 status after reset", s, 8'h00);
        rd1(8'h10, v); check8("R1 erased byte", v, 8'hFF);
    endtask

    task automatic t_latch();
        logic [7:0] s, v;
        cmd1(8'h06); rdsr(s); check8("R4 latch set", s, 8'h02);
        cmd1(8'h04); rdsr(s); check8("R4 latch clear", s, 8'h00);
        wr(8'h10, 32'hA5000000, 1);
        rdsr(s); check8("R6 no cycle without latch", s, 8'h00);
        rd1(8'h10, v); check8("R6 byte unchanged", v, 8'hFF);
    endtask

    task automatic t_write_busy();
        logic [7:0] s, v, d;
        cmd1(8'h06);
        wr(8'h20, 32'h11223300, 3);
        cs_lo(); xbyte(8'h03, d); xbyte(8'h20, d);
        checks++;
        if (miso_oe !== 1'b0) begin
            errors++;
            $display("FAIL R7: read honoured while busy actual=%b expected=0", miso_oe);
        end
        cs_hi();
        rdsr(s); check8("R7 busy and latch during cycle", s, 8'h03);
        wait_ready();
        rdsr(s); check8("R7 latch cleared after cycle", s, 8'h00);
        cs_lo(); xbyte(8'h03, d); xbyte(8'h20, d);
        xbyte(8'h00, v); check8("R2 byte 0x20", v, 8'h11);
        xbyte(8'h00, v); check8("R5 byte 0x21", v, 8'h22);
        xbyte(8'h00, v); check8("R5 byte 0x22", v, 8'h33);
        xbyte(8'h00, v); check8("R5 byte 0x23 untouched", v, 8'hFF);
        cs_hi();
    endtask

    task automatic t_group_wrap();
        logic [7:0] v;
        cmd1(8'h06); wr(8'h46, 32'hA1B2C300, 3); wait_ready();
        rd1(8'h44, v); check8("R5 group wrap to 0x44", v, 8'hC3);
        rd1(8'h45, v); check8("R5 0x45 untouched", v, 8'hFF);
        rd1(8'h47, v); check8("R5 byte 0x47", v, 8'hB2);
    endtask

    task automatic t_read_wrap();
        logic [7:0] v, d;
        cmd1(8'h06); wr(8'h00, 32'h77000000, 1); wait_ready();
        cmd1(8'h06); wr(8'hFE, 32'h5A6B0000, 2); wait_ready();
        cs_lo(); xbyte(8'h03, d); xbyte(8'hFE, d);
        xbyte(8'h00, v); check8("R3 byte 0xFE", v, 8'h5A);
        xbyte(8'h00, v); check8("R3 byte 0xFF", v, 8'h6B);
        xbyte(8'h00, v); check8("R3 wrap to 0x00", v, 8'h77);
        cs_hi();
    endtask

    task automatic t_levels();
        logic [7:0] s, v;
        cmd1(8'h06); wrsr(8'h04); wait_ready();
        rdsr(s); check8("R8 level 1 loaded", s, 8'h04);
        cmd1(8'h06); wr(8'hC4, 32'h99000000, 1);
        rdsr(s); check8("R9 guarded write keeps latch, no cycle", s, 8'h06);
        rd1(8'hC4, v); check8("R9 guarded byte unchanged", v, 8'hFF);
        wr(8'hBC, 32'h42000000, 1); wait_ready();
        rd1(8'hBC, v); check8("R8 level 1 allows 0xBC", v, 8'h42);
        cmd1(8'h06); wrsr(8'h08); wait_ready();
        cmd1(8'h06); wr(8'h80, 32'h13000000, 1);
        rdsr(s); check8("R9 level 2 guards 0x80", s, 8'h0A);
        wr(8'h7C, 32'h24000000, 1); wait_ready();
        rd1(8'h7C, v); check8("R8 level 2 allows 0x7C", v, 8'h24);
        rd1(8'h80, v); check8("R9 0x80 unchanged", v, 8'hFF);
        cmd1(8'h06); wrsr(8'h0C); wait_ready();
        cmd1(8'h06); wr(8'h08, 32'h35000000, 1);
        rdsr(s); check8("R9 level 3 guards 0x08", s, 8'h0E);
        wrsr(8'h00); wait_ready();
        rdsr(s); check8("R8 level cleared", s, 8'h00);
    endtask

    task automatic t_wp();
        logic [7:0] s, v;
        wp_n = 0;
        cmd1(8'h06);
        wr(8'h30, 32'h12000000, 1);
        rdsr(s); check8("R10 write blocked, no cycle", s, 8'h02);
        rd1(8'h30, v); check8("R10 byte unchanged", v, 8'hFF);
        wrsr(8'h0C);
        rdsr(s); check8("R10 status write blocked", s, 8'h02);
        wp_n = 1;
        cmd1(8'h04);
    endtask

    task automatic t_abort();
        logic [7:0] s, v, d;
        cmd1(8'h06);
        cs_lo(); xbyte(8'h02, d); xbyte(8'h50, d); xbyte(8'hAB, d);
        d = 8'h00; xbits(8'hFF, 3, d);
        cs_hi();
        rdsr(s); check8("R12 misaligned write, no cycle", s, 8'h02);
        rd1(8'h50, v); check8("R12 byte unchanged", v, 8'hFF);
        cmd1(8'h04);
    endtask

    task automatic t_hold();
        logic [7:0] v, d;
        cs_lo(); xbyte(8'h03, d); xbyte(8'h20, d);
        v = 8'h00;
        xbits(8'h00, 4, v);
        cw(HALF);
        hold_n = 0;
        cw(HALF);
        checks++;
        if (miso_oe !== 1'b0) begin
            errors++;
            $display("FAIL R11: miso_oe during hold actual=%b expected=0", miso_oe);
        end
        mosi = 1; sck = 1; cw(HALF); sck = 0; cw(HALF);
        hold_n = 1;
        cw(HALF);
        xbits(8'h00, 4, v);
        check8("R11 byte across hold", v, 8'h11);
        xbyte(8'h00, v); check8("R11 next byte after hold", v, 8'h22);
        cs_hi();
    endtask

    task automatic t_unknown();
        logic [7:0] v, d;
        cs_lo(); xbyte(8'hFF, d); xbyte(8'h20, d);
        checks++;
        if (miso_oe !== 1'b0) begin
            errors++;
            $display("FAIL R13: unknown opcode drives miso actual=%b expected=0", miso_oe);
        end
        cs_hi();
        rd1(8'h21, v); check8("R13 decode restarts", v, 8'h22);
    endtask

    initial begin
        cw(5);
        rst_n = 1;
        cw(5);
        t_reset();
        t_latch();
        t_write_busy();
        t_group_wrap();
        t_read_wrap();
        t_levels();
        t_wp();
        t_abort();
        t_hold();
        t_unknown();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule